// File: doc/BRIEF.md
# GPIO Bank Data and Direction Path

This block holds the pin state of one bank of general-purpose I/O. The bank keeps four registers: the pin data value, the per-pin direction, an input freeze mask and a read-back copy of the last data written by the bus. Each pin's capability is fixed when the block is built. Two parameter masks mark every pin as input-capable, output-capable, both, or neither (an absent pin). Writes to the direction and mask registers are shaped by those masks, so software cannot turn a pin into something the pad cannot do.

External pin levels pass through a two-flop synchronizer. Input pins that are not frozen then update the data value. Pins set as output change only through bus writes, and they drive their line outputs. Address decoding, ownership filtering and interrupt generation live in neighbouring blocks. Those blocks reach this one through a one-cycle write strobe with a two-bit register select, and through the register contents presented on output ports.

Top module: `gpio_bank_path`

## Requirements
- R1: A write with select 1 stores (wr_data | ~IN_CAP) & OUT_CAP into the direction register. Output-only pins therefore read 1, input-only and absent pins read 0, and bidirectional pins take the written bit. A 1 bit means output.
- R2: A write with select 2 stores wr_data & IN_CAP into the input mask register.
- R3: A write with select 0 loads wr_data & OUT_CAP into the data value bits of output pins and of input pins whose mask bit is 0, on the same clock edge. Input pins whose mask bit is 1 keep their value.
- R4: A write with select 0 also loads wr_data & OUT_CAP into the read-back register.
- R5: A write with select 3 changes no register. The read-back register changes only on writes with select 0.
- R6: An input-capable pin set as input with mask bit 0 copies its external level into the data value. The copy appears on the third rising clock edge after the level changes, because it passes two synchronizer flops first.
- R7: An input pin whose mask bit is 1 keeps its data value when its external level changes.
- R8: Data value bits of output pins, and of pins that are not input-capable, never change because of the external input.
- R9: Each line output equals the data value bit when its pin is set as output, and is 0 otherwise.
- R10: A synchronous active-low reset clears the data value, direction, mask and read-back registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pin_in | input | WIDTH | Asynchronous external pin levels |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_sel | input | 2 | Register select: 0 data, 1 direction, 2 mask, 3 read-back |
| wr_data | input | WIDTH | Write data |
| data_q | output | WIDTH | Data value register |
| dir_q | output | WIDTH | Direction register (1 = output) |
| imask_q | output | WIDTH | Input freeze mask register |
| rdbk_q | output | WIDTH | Read-back of the last data write |
| line_out | output | WIDTH | Line levels driven by output pins |

## Verification
Several properties are checked on every cycle. Direction and mask never hold bits outside their capability masks, and line outputs are never high on input pins. Output pins and frozen input pins never change without a bus data write. The read-back register stays put on non-data writes and captures the masked data on data writes, and reset clears every register. Some behaviour can only be shown by the bench's scenarios. These are the exact direction formula for each pin class, the three-edge latency of the synchronizer, and which bits a data write reaches when masked and unmasked input pins are mixed.

// File: rtl/gpio_bank_pkg.sv
// Shared register-select encoding for the GPIO bank data path.
// Assumes a two-bit select supplied by an external decoder.
package gpio_bank_pkg;
    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_RDBK = 2'd3
    } bank_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes each bit is independent; no bus coherency is implied.
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the pin levels one flop further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[s] <= '0;
                else if (s == 0)
                    stage_q[s] <= async_in;
                else
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_cfg_regs.sv
// Direction, input mask and read-back registers of one bank.
// Assumes writes arrive as a one-cycle strobe with a decoded select;
// capability masks are fixed at build time.
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int               WIDTH   = 32,
    parameter logic [WIDTH-1:0] IN_CAP  = '1,
    parameter logic [WIDTH-1:0] OUT_CAP = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] imask_q,
    output logic [WIDTH-1:0] rdbk_q
);
    localparam logic [WIDTH-1:0] FORCE_OUT = ~IN_CAP & OUT_CAP;

    logic hit_dir, hit_mask, hit_data;
    assign hit_dir  = wr_en && (wr_sel == SEL_DIR);
    assign hit_mask = wr_en && (wr_sel == SEL_MASK);
    assign hit_data = wr_en && (wr_sel == SEL_DATA);

    // Direction: pins that can only drive are forced to output.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dir_q <= '0;
        else if (hit_dir)
            dir_q <= (wr_data & OUT_CAP) | FORCE_OUT;
    end

    // Freeze mask: kept only for pins that can sense.
    always_ff @(posedge clk) begin
        if (!rst_n)
            imask_q <= '0;
        else if (hit_mask)
            imask_q <= wr_data & IN_CAP;
    end

    // Read-back copy of data writes; its own select is ignored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdbk_q <= '0;
        else if (hit_data)
            rdbk_q <= wr_data & OUT_CAP;
    end
endmodule

// File: rtl/gpio_data_reg.sv
// Data value register and line drivers of one bank.
// Assumes pin_sync is already synchronized; a bus write takes
// precedence over sampling in the cycle it occurs.
module gpio_data_reg #(
    parameter int               WIDTH   = 32,
    parameter logic [WIDTH-1:0] IN_CAP  = '1,
    parameter logic [WIDTH-1:0] OUT_CAP = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] dir,
    input  logic [WIDTH-1:0] imask,
    input  logic [WIDTH-1:0] pin_sync,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] line_out
);
    logic [WIDTH-1:0] data_nxt;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            // Pick the next level of one pin: bus, sampled input, or hold.
            always_comb begin
                if (bus_wr && (dir[i] || !imask[i]))
                    data_nxt[i] = wr_data[i] & OUT_CAP[i];
                else if (IN_CAP[i] && !dir[i] && !imask[i])
                    data_nxt[i] = pin_sync[i];
                else
                    data_nxt[i] = data_q[i];
            end
            assign line_out[i] = dir[i] & data_q[i];
        end
    endgenerate

    // Hold the bank's current pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else
            data_q <= data_nxt;
    end
endmodule

// File: rtl/gpio_bank_path.sv
// Top of the GPIO bank data and direction path.
// Assumes an external decoder supplies wr_en/wr_sel and that
// interrupt and ownership logic observe the outputs.
module gpio_bank_path
    import gpio_bank_pkg::*;
#(
    parameter int               WIDTH       = 32,
    parameter int               SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] IN_CAP      = 32'h0FFF_00FF,
    parameter logic [WIDTH-1:0] OUT_CAP     = 32'h00FF_FFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] imask_q,
    output logic [WIDTH-1:0] rdbk_q,
    output logic [WIDTH-1:0] line_out
);
    logic [WIDTH-1:0] pin_sync;
    logic             data_hit;

    assign data_hit = wr_en && (wr_sel == SEL_DATA);

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    gpio_cfg_regs #(.WIDTH(WIDTH), .IN_CAP(IN_CAP), .OUT_CAP(OUT_CAP)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .dir_q   (dir_q),
        .imask_q (imask_q),
        .rdbk_q  (rdbk_q)
    );

    gpio_data_reg #(.WIDTH(WIDTH), .IN_CAP(IN_CAP), .OUT_CAP(OUT_CAP)) u_data (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (data_hit),
        .wr_data  (wr_data),
        .dir      (dir_q),
        .imask    (imask_q),
        .pin_sync (pin_sync),
        .data_q   (data_q),
        .line_out (line_out)
    );
endmodule

// File: rtl/gpio_bank_path_chk.sv
// Property checker for gpio_bank_path, attached by bind.
// Assumes the select encoding of gpio_bank_pkg.
module gpio_bank_path_chk
    import gpio_bank_pkg::*;
#(
    parameter int               WIDTH   = 32,
    parameter logic [WIDTH-1:0] IN_CAP  = '1,
    parameter logic [WIDTH-1:0] OUT_CAP = '1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [WIDTH-1:0] wr_data,
    input logic [WIDTH-1:0] data_q,
    input logic [WIDTH-1:0] dir_q,
    input logic [WIDTH-1:0] imask_q,
    input logic [WIDTH-1:0] rdbk_q,
    input logic [WIDTH-1:0] line_out
);
    // R1
    dir_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_q & ~OUT_CAP) == '0);

    // R2
    mask_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (imask_q & ~IN_CAP) == '0);

    // R4
    rdbk_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_DATA) |=> rdbk_q == ($past(wr_data) & OUT_CAP));

    // R5
    rdbk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel != SEL_DATA) |=> $stable(rdbk_q));

    // R7
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((data_q ^ $past(data_q)) & $past(~dir_q & imask_q)) == '0);

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel == SEL_DATA) |=>
            ((data_q ^ $past(data_q)) & $past(dir_q | ~IN_CAP)) == '0);

    // R9
    line_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_out & ~dir_q) == '0);

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (data_q == '0 && dir_q == '0 && imask_q == '0 && rdbk_q == '0));
endmodule

bind gpio_bank_path gpio_bank_path_chk #(
    .WIDTH(WIDTH), .IN_CAP(IN_CAP), .OUT_CAP(OUT_CAP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .data_q(data_q), .dir_q(dir_q),
    .imask_q(imask_q), .rdbk_q(rdbk_q), .line_out(line_out)
);

// File: tb/gpio_bank_path_test.sv
module gpio_bank_path_test;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] pin_in = '0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] data_q, dir_q, imask_q, rdbk_q, line_out;

    int  total = 0;
    int  fails = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    gpio_bank_path uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .data_q(data_q), .dir_q(dir_q),
        .imask_q(imask_q), .rdbk_q(rdbk_q), .line_out(line_out)
    );

    // Vector: {select, write data, expected value of the selected register}
    // Pins 0-7, 16-23 bidirectional; 8-15 output only; 24-27 input only; 28-31 absent.
    localparam logic [65:0] VEC [7] = '{
        {2'd1, 32'h0000_0000, 32'h0000_FF00},  // R1 forced outputs
        {2'd1, 32'hFFFF_FFFF, 32'h00FF_FFFF},  // R1 input-only/absent stay 0
        {2'd1, 32'h0000_00A5, 32'h0000_FFA5},  // R1 bidirectional take data
        {2'd2, 32'hFFFF_FFFF, 32'h0FFF_00FF},  // R2
        {2'd2, 32'h1234_5678, 32'h0234_0078},  // R2
        {2'd0, 32'hFFFF_FFFF, 32'h00FF_FFFF},  // R4
        {2'd3, 32'hDEAD_BEEF, 32'h00FF_FFFF}   // R5 read-back ignores write
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic set_pins(input logic [W-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 data", data_q, '0);
        check("R10 dir", dir_q, '0);
        check("R10 mask", imask_q, '0);
        check("R10 rdbk", rdbk_q, '0);
        check("R9 line at reset", line_out, '0);
        rst_n = 1'b1;

        for (int k = 0; k < 7; k++) begin
            logic [1:0]   s;
            logic [W-1:0] d, e;
            {s, d, e} = VEC[k];
            bus_write(s, d);
            case (s)
                2'd1:    check("R1 table", dir_q, e);
                2'd2:    check("R2 table", imask_q, e);
                default: check("R4/R5 table", rdbk_q, e);
            endcase
        end

        bus_write(2'd1, 32'h0000_FFFF);
        bus_write(2'd2, 32'h0000_0000);
        repeat (4) @(negedge clk);
        bus_write(2'd0, 32'hFFFF_FFFF);
        check("R3 unmasked inputs take bus data", data_q, 32'h00FF_FFFF);
        check("R4 read-back", rdbk_q, 32'h00FF_FFFF);
        @(negedge clk);
        check("R6 inputs resample low", data_q, 32'h0000_FFFF);
        check("R9 line follows outputs", line_out, 32'h0000_FFFF);

        set_pins(32'hFFFF_FFFF);
        check("R6 inputs follow high", data_q, 32'h0FFF_FFFF);
        check("R9 line unaffected by inputs", line_out, 32'h0000_FFFF);
        set_pins(32'h0000_0000);
        check("R8 outputs ignore pins", data_q, 32'h0000_FFFF);
        set_pins(32'hFFFF_FFFF);

        // Latency: unchanged after two edges, updated on the third (R6)
        @(negedge clk); pin_in = 32'h0000_0000;
        repeat (2) @(negedge clk);
        check("R6 not yet after two edges", data_q, 32'h0FFF_FFFF);
        @(negedge clk);
        check("R6 updated on third edge", data_q, 32'h0000_FFFF);
        set_pins(32'hFFFF_FFFF);

        bus_write(2'd2, 32'hF001_0000);
        check("R2 mask keeps input-capable", imask_q, 32'h0001_0000);
        set_pins(32'h0000_0000);
        check("R7 frozen pin holds", data_q, 32'h0001_FFFF);

        bus_write(2'd0, 32'h0000_0000);
        check("R3 masked pin skips bus", data_q, 32'h0001_0000);
        check("R9 line cleared", line_out, 32'h0000_0000);
        check("R4 read-back zero", rdbk_q, 32'h0000_0000);

        bus_write(2'd0, 32'h0000_00A5);
        check("R9 line follows write", line_out, 32'h0000_00A5);
        bus_write(2'd3, 32'h0000_1234);
        check("R5 read-back unchanged", rdbk_q, 32'h0000_00A5);
        check("R5 data unchanged", data_q, 32'h0001_00A5);

        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R10 data after reset", data_q, '0);
        check("R10 dir after reset", dir_q, '0);
        check("R10 mask after reset", imask_q, '0);
        check("R10 rdbk after reset", rdbk_q, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule